// File: doc/BRIEF.md
# Lane-Striped Packet Receive Deframer

The deframer sits behind the receive lanes of a serial link. The lanes have already been aligned, deskewed and put in order. On every cycle where `in_valid` is high it takes one beat of `NUM_LANES` bytes. It looks for a packet header and checks the header's check byte. It then sorts the packet into one of two kinds. A short packet carries its 16-bit payload in the header. A long packet carries `word count` payload bytes and a 16-bit CRC after the header. The block packs long-packet payload into `APP_WIDTH`-bit application words and compares the received CRC with one it computes itself.

The controller has four states. HUNT waits for a header start. HEAD collects the rest of a header that spans more than one beat. DATA takes payload beats. CRC takes the checksum beats. The transitions are:
- HUNT→HEAD when a nonzero first byte arrives and the header needs more beats.
- HUNT or HEAD go to a header decision when the last header beat arrives. The decision returns to HUNT if the check byte is bad or the packet is short. It goes to DATA for a long packet with a nonzero count, and to CRC for a long packet with a zero count.
- DATA→CRC on the final payload beat.
- CRC→HUNT on the final checksum beat.

`in_valid` low freezes the state in every state.

Top module: `rx_deframer`

## Requirements
- R1: The header is four bytes: data ID, count low byte, count high byte, then a check byte equal to ID ^ low ^ high ^ 0x5A. Stream byte order runs lane 0 first, then up through the lanes, then on to the next beat.
- R2: Beats with `in_valid` low are ignored in every state. In HUNT, a valid beat whose lane-0 byte is 0x00 is idle and is ignored.
- R3: A data ID below 0x10 marks a short packet. `rx_sop` and `rx_valid` pulse together one cycle after the header's last beat, with `rx_word_count` carrying the 16-bit payload.
- R4: For a long packet, `rx_sop` and `rx_valid` first assert together, one cycle after the beat that completes the first application word (or ends the payload). Payload byte k of a word sits at bits [8k+7:8k].
- R5: After the first word, `rx_valid` pulses once per full word and once more for a final partial word. In a partial word, only the low `count mod (APP_WIDTH/8)` bytes are defined.
- R6: Long-packet payload is zero-padded to a multiple of `NUM_LANES` bytes. It is followed by the CRC, low byte first, also padded to a beat boundary.
- R7: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first over the payload bytes only. On a mismatch, `rx_crc_bad` is a one-cycle pulse one cycle after the final CRC beat, after the last word. On a match, no pulse is given.
- R8: A header with a wrong check byte produces no output. The block returns to HUNT and receives the next packet normally.
- R9: A long packet with a count of zero gives one `rx_sop`/`rx_valid` pulse with no defined data bytes, one cycle after its header. It then consumes its CRC beats, and the expected CRC is 0xFFFF.
- R10: While reset is asserted, `rx_sop`, `rx_valid` and `rx_crc_bad` are low.
- R11: `rx_data_id` and `rx_word_count` hold their values on every `rx_valid` cycle of a long packet after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat on `in_data` is valid |
| in_data | input | NUM_LANES*8 | Lane bytes, lane 0 in bits [7:0] |
| rx_sop | output | 1 | Start of packet, with first `rx_valid` |
| rx_valid | output | 1 | Word or short packet delivered this cycle |
| rx_data_id | output | 8 | Data ID of current packet |
| rx_word_count | output | 16 | Byte count (long) or payload (short) |
| rx_data | output | APP_WIDTH | Application word |
| rx_crc_bad | output | 1 | One-cycle CRC mismatch pulse |

## Verification
The stimulus mixes several cases: short packets, and long packets whose counts are exact word multiples, below one word, or one byte past a word. This separates correct word flushing from early or late partial delivery. Packets with one corrupted CRC byte are set against clean ones, to show that the mismatch pulse depends on the data and is not always raised. A header with a broken check byte, placed just before a good packet, shows whether the block resynchronises. Idle zero beats and stalled beats carrying all-ones data expose any byte that is consumed when it should have been skipped. A zero-count long packet checks the empty-payload path into CRC.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HEAD = 2'd1,
        ST_DATA = 2'd2,
        ST_CRC  = 2'd3
    } rxdf_state_e;

    localparam logic [7:0]  HDR_SALT = 8'h5A;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/rx_hdr_decode.sv
module rx_hdr_decode
    import rxdf_pkg::*;
#(
    parameter logic [7:0] SHORT_ID_LIMIT = 8'h10
) (
    input  logic [31:0] hdr,
    output logic [7:0]  id,
    output logic [15:0] count,
    output logic        check_ok,
    output logic        is_short
);
    always_comb begin
        id       = hdr[7:0];
        count    = hdr[23:8];
        check_ok = (hdr[31:24] == (hdr[7:0] ^ hdr[15:8] ^ hdr[23:16] ^ HDR_SALT));
        is_short = (hdr[7:0] < SHORT_ID_LIMIT);
    end
endmodule

// File: rtl/rx_crc_acc.sv
module rx_crc_acc
    import rxdf_pkg::*;
#(
    parameter int NUM_LANES = 2,
    localparam int CW = $clog2(NUM_LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic [NUM_LANES*8-1:0] data,
    input  logic [CW-1:0]          nbytes,
    output logic [15:0]            crc
);
    logic [15:0] crc_q, crc_step;

    always_comb begin
        crc_step = crc_q;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (i < int'(nbytes)) crc_step = crc16_byte(crc_step, data[i*8 +: 8]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= CRC_INIT;
        else if (clr) crc_q <= CRC_INIT;
        else if (en)  crc_q <= crc_step;
    end

    assign crc = crc_q;
endmodule

// File: rtl/rx_word_pack.sv
module rx_word_pack #(
    parameter int NUM_LANES = 2,
    parameter int APP_WIDTH = 32,
    localparam int LB = NUM_LANES * 8,
    localparam int AB = APP_WIDTH / 8,
    localparam int PW = $clog2(AB) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 last,
    input  logic [LB-1:0]        data,
    output logic [APP_WIDTH-1:0] word,
    output logic                 flush
);
    localparam logic [PW-1:0] STEP = PW'(NUM_LANES);
    localparam logic [PW-1:0] FULL = PW'(AB);

    logic [PW-1:0]        pos_q;
    logic [APP_WIDTH-1:0] buf_q;

    always_comb begin
        word = buf_q;
        word[int'(pos_q)*8 +: LB] = data;
        flush = en && (last || (pos_q + STEP >= FULL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            buf_q <= '0;
        end else if (clr || flush) begin
            pos_q <= '0;
            buf_q <= '0;
        end else if (en) begin
            pos_q <= pos_q + STEP;
            buf_q <= word;
        end
    end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import rxdf_pkg::*;
#(
    parameter int         NUM_LANES      = 2,
    parameter int         APP_WIDTH      = 32,
    parameter logic [7:0] SHORT_ID_LIMIT = 8'h10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NUM_LANES*8-1:0] in_data,
    output logic                   rx_sop,
    output logic                   rx_valid,
    output logic [7:0]             rx_data_id,
    output logic [15:0]            rx_word_count,
    output logic [APP_WIDTH-1:0]   rx_data,
    output logic                   rx_crc_bad
);
    localparam int          LB      = NUM_LANES * 8;
    localparam int          HB      = 4 / NUM_LANES;
    localparam int          CB      = (2 + NUM_LANES - 1) / NUM_LANES;
    localparam int          CW      = $clog2(NUM_LANES + 1);
    localparam logic [1:0]  HB_LAST = 2'(HB - 1);
    localparam logic [1:0]  CB_LAST = 2'(CB - 1);
    localparam logic [15:0] NL16    = 16'(NUM_LANES);

    rxdf_state_e state_q, state_d, dec_next;
    logic [1:0]  beat_q;
    logic [31:0] hdr_q, hdr_cand, in_ext;
    logic [15:0] rem_q, crcr_q, crc_cand, crc_calc;
    logic        first_q;

    logic [7:0]  d_id;
    logic [15:0] d_count;
    logic        d_ok, d_short;
    logic        start_hdr, hdr_done, data_beat, last_beat, crc_beat, crc_last;
    logic [CW-1:0]        take_n;
    logic [APP_WIDTH-1:0] pack_word;
    logic                 pack_flush;

    always_comb begin
        in_ext           = '0;
        in_ext[LB-1:0]   = in_data;
        hdr_cand  = ((state_q == ST_HUNT) ? 32'h0 : hdr_q) | (in_ext << (LB * int'(beat_q)));
        crc_cand  = crcr_q | 16'(in_ext << (LB * int'(beat_q)));
        start_hdr = in_valid && (state_q == ST_HUNT) && (in_data[7:0] != 8'h00);
        hdr_done  = (start_hdr && (HB == 1)) ||
                    (in_valid && (state_q == ST_HEAD) && (beat_q == HB_LAST));
        data_beat = in_valid && (state_q == ST_DATA);
        last_beat = (rem_q <= NL16);
        take_n    = last_beat ? CW'(rem_q) : CW'(NUM_LANES);
        crc_beat  = in_valid && (state_q == ST_CRC);
        crc_last  = (beat_q == CB_LAST);
    end

    rx_hdr_decode #(.SHORT_ID_LIMIT(SHORT_ID_LIMIT)) u_hdr (
        .hdr(hdr_cand), .id(d_id), .count(d_count), .check_ok(d_ok), .is_short(d_short)
    );

    rx_crc_acc #(.NUM_LANES(NUM_LANES)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(hdr_done), .en(data_beat),
        .data(in_data), .nbytes(take_n), .crc(crc_calc)
    );

    rx_word_pack #(.NUM_LANES(NUM_LANES), .APP_WIDTH(APP_WIDTH)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(hdr_done), .en(data_beat), .last(last_beat),
        .data(in_data), .word(pack_word), .flush(pack_flush)
    );

    // header decision: drop, finish short, or enter payload / checksum
    always_comb begin
        if (!d_ok || d_short)     dec_next = ST_HUNT;
        else if (d_count == 16'd0) dec_next = ST_CRC;
        else                       dec_next = ST_DATA;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (start_hdr) state_d = (HB == 1) ? dec_next : ST_HEAD;
            ST_HEAD: if (hdr_done)  state_d = dec_next;
            ST_DATA: if (data_beat && last_beat) state_d = ST_CRC;
            ST_CRC:  if (crc_beat && crc_last)   state_d = ST_HUNT;
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            hdr_q   <= '0;
            rem_q   <= '0;
            crcr_q  <= '0;
            first_q <= 1'b0;
        end else begin
            if (state_q == ST_HUNT && state_d == ST_HEAD) beat_q <= 2'd1;
            else if (state_d != state_q)                  beat_q <= '0;
            else if (in_valid && (state_q == ST_HEAD || state_q == ST_CRC)) beat_q <= beat_q + 2'd1;

            if (in_valid && (state_q == ST_HUNT || state_q == ST_HEAD)) hdr_q <= hdr_cand;
            if (hdr_done) begin
                rem_q   <= d_count;
                first_q <= d_ok && !d_short;
            end else if (data_beat) begin
                rem_q <= rem_q - 16'(take_n);
            end
            if (pack_flush) first_q <= 1'b0;

            if (state_d == ST_CRC && state_q != ST_CRC) crcr_q <= '0;
            else if (crc_beat)                          crcr_q <= crc_cand;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sop        <= 1'b0;
            rx_valid      <= 1'b0;
            rx_data_id    <= '0;
            rx_word_count <= '0;
            rx_data       <= '0;
            rx_crc_bad    <= 1'b0;
        end else begin
            rx_sop     <= 1'b0;
            rx_valid   <= 1'b0;
            rx_crc_bad <= 1'b0;
            if (hdr_done && d_ok) begin
                rx_data_id    <= d_id;
                rx_word_count <= d_count;
                if (d_short || d_count == 16'd0) begin
                    rx_sop   <= 1'b1;
                    rx_valid <= 1'b1;
                    rx_data  <= '0;
                end
            end
            if (pack_flush) begin
                rx_sop   <= first_q;
                rx_valid <= 1'b1;
                rx_data  <= pack_word;
            end
            if (crc_beat && crc_last) rx_crc_bad <= (crc_cand != crc_calc);
        end
    end
endmodule

// File: rtl/rx_deframer_chk.sv
module rx_deframer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_sop,
    input logic        rx_valid,
    input logic [7:0]  rx_data_id,
    input logic [15:0] rx_word_count,
    input logic        rx_crc_bad
);
    // R4
    sop_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sop |-> rx_valid);

    // R7
    crc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_bad |=> !rx_crc_bad);

    // R7
    crc_after_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crc_bad |-> !rx_valid);

    // R11
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_sop) |-> ($stable(rx_data_id) && $stable(rx_word_count)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_sop && !rx_valid && !rx_crc_bad));
endmodule

bind rx_deframer rx_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_valid(rx_valid),
    .rx_data_id(rx_data_id), .rx_word_count(rx_word_count), .rx_crc_bad(rx_crc_bad)
);

// File: tb/tb_rx_deframer.sv
module tb_rx_deframer;
    localparam int NL = 2;
    localparam int AW = 32;
    localparam int AB = AW / 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [NL*8-1:0] in_data = '0;
    logic           rx_sop, rx_valid, rx_crc_bad;
    logic [7:0]     rx_data_id;
    logic [15:0]    rx_word_count;
    logic [AW-1:0]  rx_data;

    always #4 clk = ~clk;

    rx_deframer #(.NUM_LANES(NL), .APP_WIDTH(AW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_data_id(rx_data_id),
        .rx_word_count(rx_word_count), .rx_data(rx_data), .rx_crc_bad(rx_crc_bad)
    );

    typedef struct packed {
        logic [7:0]  id;
        logic [15:0] wc;
        logic [7:0]  seed;
        logic        bad_crc;
        logic        bad_hdr;
        logic        gaps;
    } row_t;

    // stimulus rows: short (R3), long exact / partial (R4 R5), bad CRC (R7),
    // bad check byte (R8), stalls (R2), zero count (R9)
    localparam row_t ROWS [9] = '{
        '{8'h05, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0},
        '{8'h22, 16'd8,    8'h11, 1'b0, 1'b0, 1'b0},
        '{8'h31, 16'd3,    8'h40, 1'b0, 1'b0, 1'b0},
        '{8'h40, 16'd5,    8'h73, 1'b1, 1'b0, 1'b0},
        '{8'h41, 16'd1,    8'h09, 1'b0, 1'b1, 1'b0},
        '{8'h0F, 16'hBEEF, 8'h00, 1'b0, 1'b0, 1'b1},
        '{8'h7E, 16'd9,    8'hC2, 1'b0, 1'b0, 1'b1},
        '{8'h10, 16'd0,    8'h00, 1'b0, 1'b0, 1'b0},
        '{8'h55, 16'd4,    8'hE8, 1'b1, 1'b0, 1'b1}
    };

    typedef struct packed {
        logic        is_crc;
        logic        sop;
        logic [7:0]  id;
        logic [15:0] wc;
        logic [31:0] data;
        int          nvalid;
        int          req;
    } ev_t;

    ev_t        expq[$];
    logic [7:0] bq[$];
    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [7:0] b);
        logic [15:0] c = c0;
        for (int i = 0; i < 8; i++) begin
            if (c[15] ^ b[7-i]) c = (c << 1) ^ 16'h1021;
            else                c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic check(input int req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic [NL*8-1:0] d);
        @(posedge clk);
        #1;
        in_valid = v;
        in_data  = d;
    endtask

    // monitor: every delivered word or CRC pulse is compared with the model
    always @(negedge clk) begin
        if (rst_n && (rx_valid || rx_crc_bad)) begin
            if (expq.size() == 0) begin
                check(5, 1'b0, {63'd0, rx_valid}, 64'd0);
            end else begin
                ev_t e;
                logic ok;
                e = expq.pop_front();
                if (e.is_crc) begin
                    // R7 mismatch pulse
                    check(7, rx_crc_bad && !rx_valid, {62'd0, rx_crc_bad, rx_valid}, 64'd2);
                end else begin
                    ok = rx_valid && !rx_crc_bad && (rx_sop == e.sop) &&
                         (rx_data_id == e.id) && (rx_word_count == e.wc);
                    for (int j = 0; j < AB; j++)
                        if (j < e.nvalid && rx_data[j*8 +: 8] != e.data[j*8 +: 8]) ok = 1'b0;
                    check(e.req, ok, {7'd0, rx_sop, rx_data_id, rx_word_count, rx_data},
                          {7'd0, e.sop, e.id, e.wc, e.data});
                end
            end
        end
    end

    task automatic run_row(input row_t r, input bit idle_after);
        logic [7:0]  lo, hi, chk;
        logic [15:0] crc;
        ev_t e;
        int nb;
        bq.delete();
        lo  = r.wc[7:0];
        hi  = r.wc[15:8];
        chk = r.id ^ lo ^ hi ^ 8'h5A;           // R1 check byte
        if (r.bad_hdr) chk = chk ^ 8'hFF;
        bq.push_back(r.id); bq.push_back(lo); bq.push_back(hi); bq.push_back(chk);
        if (!r.bad_hdr) begin
            if (r.id < 8'h10) begin
                e = '{1'b0, 1'b1, r.id, r.wc, 32'd0, 0, 3};          // R3
                expq.push_back(e);
            end else begin
                crc = 16'hFFFF;
                for (int i = 0; i < int'(r.wc); i++) crc = ref_crc(crc, pay(r.seed, i));
                if (r.wc == 16'd0) begin
                    e = '{1'b0, 1'b1, r.id, r.wc, 32'd0, 0, 9};      // R9
                    expq.push_back(e);
                end
                for (int k = 0; k * AB < int'(r.wc); k++) begin
                    e.is_crc = 1'b0;
                    e.sop    = (k == 0);
                    e.id     = r.id;
                    e.wc     = r.wc;
                    e.data   = '0;
                    e.nvalid = (int'(r.wc) - k*AB > AB) ? AB : int'(r.wc) - k*AB;
                    e.req    = (k == 0) ? 4 : 5;                     // R4 / R5
                    for (int j = 0; j < e.nvalid; j++) e.data[j*8 +: 8] = pay(r.seed, k*AB + j);
                    expq.push_back(e);
                end
                if (r.bad_crc) begin
                    crc[0] = ~crc[0];
                    e = '{1'b1, 1'b0, 8'd0, 16'd0, 32'd0, 0, 7};     // R7
                    expq.push_back(e);
                end
            end
        end
        if (r.id >= 8'h10) begin
            for (int i = 0; i < int'(r.wc); i++) bq.push_back(pay(r.seed, i));
            while (bq.size() % NL != 0) bq.push_back(8'h00);        // R6 padding
            bq.push_back(crc[7:0]); bq.push_back(crc[15:8]);
            while (bq.size() % NL != 0) bq.push_back(8'h00);
        end
        nb = bq.size() / NL;
        for (int b = 0; b < nb; b++) begin
            if (r.gaps && (b % 2 == 1)) beat(1'b0, '1);              // R2 stall beat
            beat(1'b1, {bq[b*NL+1], bq[b*NL]});
        end
        if (idle_after) beat(1'b1, '0);                              // R2 idle beat
        beat(1'b0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check(10, !rx_sop && !rx_valid && !rx_crc_bad, {61'd0, rx_sop, rx_valid, rx_crc_bad}, 64'd0);
        in_valid = 1'b1;
        in_data  = 16'hA1A1;
        @(posedge clk); #1;
        check(10, !rx_sop && !rx_valid && !rx_crc_bad, {61'd0, rx_sop, rx_valid, rx_crc_bad}, 64'd0);
        in_valid = 1'b0;
        in_data  = '0;
        rst_n    = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        foreach (ROWS[i]) run_row(ROWS[i], (i % 2) == 0);
        repeat (12) beat(1'b0, '0);
        // R5 R8: every expected delivery seen, nothing extra
        check(8, expq.size() == 0, 64'(expq.size()), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule